// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block takes configuration words over a three-wire serial link made of a serial clock, a data line and a load-enable strobe. The block samples all three wires into the system clock domain and detects their edges there. Each rising edge of the serial clock moves one data bit into a 24-bit shift register, with the most significant bit first.

When load enable rises, the two bits that were shifted in last act as an address. That address selects one of four control words: IF reference, IF divider, RF reference or RF divider. The other 22 bits of the shift register are copied into the selected control word. The control words are presented as flat outputs. A few fields are also brought out on ports of their own: the RF charge-pump current code, the IF charge-pump gain bit, and two general-purpose output pins that are taken from the IF divider word.

A one-cycle strobe shows which control word was written. Downstream logic can use it to pick up new settings, and a bench can use it to confirm the routing.

Top module: `serial_cfg_port`

## Requirements
- R1: After synchronous reset, all four control words, rf_cp_code_o, if_cp_hi_o, gpo0_o, gpo1_o and load_stb_o are zero.
- R2: Each rising edge of cfg_sclk_i shifts cfg_sdat_i into the shift register, most significant bit first. On a load, the target control word takes shift-register bits [23:2], so bit 23 of the word becomes bit 21 of the control word.
- R3: Shift-register bits [1:0] select the target control word: 00 selects IF reference, 01 selects IF divider, 10 selects RF reference and 11 selects RF divider. The other three control words keep their values.
- R4: A load happens only on a rising edge of cfg_le_i. Serial clock edges that arrive while cfg_le_i is high change no control word. The bits shifted during that time are loaded at the next rising edge of cfg_le_i.
- R5: Each load raises load_stb_o for exactly one system clock cycle. Only bit N is high, where N is the 2-bit address, and the strobe is in the same cycle as the control-word change.
- R6: gpo0_o equals bit 17 of the last 24-bit word loaded at address 01. gpo1_o equals bit 18 of that word.
- R7: rf_cp_code_o equals bits [21:18] of the last word loaded at address 10. Code 0 selects the smallest current and code 15 the largest.
- R8: if_cp_hi_o equals bit 20 of the last word loaded at address 00. The value 1 selects the high IF charge-pump current.
- R9: If more than 24 bits are shifted before a load, only the last 24 bits count.
- R10: The control word and the strobe change after the third rising system clock edge that follows cfg_le_i going high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sclk_i | input | 1 | Serial clock; shifts on its rising edge |
| cfg_sdat_i | input | 1 | Serial data, MSB first |
| cfg_le_i | input | 1 | Load enable; a rising edge loads a control word |
| if_ref_word_o | output | 22 | IF reference control word (address 00) |
| if_div_word_o | output | 22 | IF divider control word (address 01) |
| rf_ref_word_o | output | 22 | RF reference control word (address 10) |
| rf_div_word_o | output | 22 | RF divider control word (address 11) |
| rf_cp_code_o | output | 4 | RF charge-pump current code |
| if_cp_hi_o | output | 1 | IF charge-pump high-current select |
| gpo0_o | output | 1 | General-purpose output 0 |
| gpo1_o | output | 1 | General-purpose output 1 |
| load_stb_o | output | 4 | One-hot, one-cycle load indication |

## Verification
Every wire passes through a two-stage synchronizer and then an edge register. As a result, a shift or a load takes effect on the third system clock edge after the wire changes.

The bench changes the wires on falling clock edges and holds each serial level for several cycles, so every bit is captured. It checks the control words once load enable has been high for six cycles. For R10, it checks the outputs a short delay after the second rising edge, where they must still hold their old values, and again after the third rising edge, where they must hold the new values. A monitor counts strobe pulses a short time after each rising edge, so that every load can be checked for exactly one pulse on the right bit.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  // Serial word geometry
  localparam int WORD_W   = 24;
  localparam int ADDR_W   = 2;
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int NUM_SLOT = 1 << ADDR_W;

  // Control-word slot addresses (the trailing two serial bits)
  typedef enum logic [ADDR_W-1:0] {
    SLOT_IF_REF = 2'b00,
    SLOT_IF_DIV = 2'b01,
    SLOT_RF_REF = 2'b10,
    SLOT_RF_DIV = 2'b11
  } slot_e;

  // Field positions, given as bit numbers within the 24-bit serial word
  localparam int GPO0_WBIT    = 17;
  localparam int GPO1_WBIT    = 18;
  localparam int RFCP_WLSB    = 18;
  localparam int RFCP_W       = 4;
  localparam int IFGAIN_WBIT  = 20;

  // Serial-word bit number to control-word (payload) bit number
  function automatic int pay_idx(input int wbit);
    return wbit - ADDR_W;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/cfg_edge.sv
module cfg_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] sr_q;

  // MSB-first: new bits enter at the bottom and older bits move upward
  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign word_o = sr_q;

endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2,
  localparam int PAY_W    = WORD_W - ADDR_W,
  localparam int NUM_SLOT = 1 << ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [WORD_W-1:0]         word_i,
  output logic [NUM_SLOT*PAY_W-1:0] slots_o,
  output logic [NUM_SLOT-1:0]       stb_o
);

  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  payload;

  assign addr    = word_i[ADDR_W-1:0];
  assign payload = word_i[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    logic [PAY_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                              q <= '0;
      else if (load_i && (int'(addr) == g)) q <= payload;
    end
    assign slots_o[g*PAY_W +: PAY_W] = q;
  end

  logic [NUM_SLOT-1:0] stb_q;

  always_ff @(posedge clk) begin
    if (rst)         stb_q <= '0;
    else if (load_i) stb_q <= NUM_SLOT'(1) << addr;
    else             stb_q <= '0;
  end

  assign stb_o = stb_q;

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_sclk_i,
  input  logic                cfg_sdat_i,
  input  logic                cfg_le_i,
  output logic [PAY_W-1:0]    if_ref_word_o,
  output logic [PAY_W-1:0]    if_div_word_o,
  output logic [PAY_W-1:0]    rf_ref_word_o,
  output logic [PAY_W-1:0]    rf_div_word_o,
  output logic [RFCP_W-1:0]   rf_cp_code_o,
  output logic                if_cp_hi_o,
  output logic                gpo0_o,
  output logic                gpo1_o,
  output logic [NUM_SLOT-1:0] load_stb_o
);

  // Synchronized pins, ordered {le, sdat, sclk}
  logic [2:0] pins_s;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({cfg_le_i, cfg_sdat_i, cfg_sclk_i}),
    .sync_o  (pins_s)
  );

  // Rising edges of {le, sclk}
  logic [1:0] rise;

  cfg_edge #(.W(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({pins_s[2], pins_s[0]}),
    .rise_o (rise)
  );

  logic [WORD_W-1:0] sr_word;

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_i (rise[0]),
    .bit_i   (pins_s[1]),
    .word_o  (sr_word)
  );

  logic [NUM_SLOT*PAY_W-1:0] slots;

  cfg_latch_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load_i  (rise[1]),
    .word_i  (sr_word),
    .slots_o (slots),
    .stb_o   (load_stb_o)
  );

  assign if_ref_word_o = slots[int'(SLOT_IF_REF)*PAY_W +: PAY_W];
  assign if_div_word_o = slots[int'(SLOT_IF_DIV)*PAY_W +: PAY_W];
  assign rf_ref_word_o = slots[int'(SLOT_RF_REF)*PAY_W +: PAY_W];
  assign rf_div_word_o = slots[int'(SLOT_RF_DIV)*PAY_W +: PAY_W];

  // Fields taken straight from the latch flops
  assign rf_cp_code_o = rf_ref_word_o[pay_idx(RFCP_WLSB) +: RFCP_W];
  assign if_cp_hi_o   = if_ref_word_o[pay_idx(IFGAIN_WBIT)];
  assign gpo0_o       = if_div_word_o[pay_idx(GPO0_WBIT)];
  assign gpo1_o       = if_div_word_o[pay_idx(GPO1_WBIT)];

endmodule

// File: rtl/serial_cfg_chk.sv
module serial_cfg_chk (
  input logic        clk,
  input logic        rst,
  input logic [21:0] if_ref_word_o,
  input logic [21:0] if_div_word_o,
  input logic [21:0] rf_ref_word_o,
  input logic [21:0] rf_div_word_o,
  input logic [3:0]  rf_cp_code_o,
  input logic        if_cp_hi_o,
  input logic        gpo0_o,
  input logic        gpo1_o,
  input logic [3:0]  load_stb_o
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst_d |-> (load_stb_o == '0 && if_ref_word_o == '0 && if_div_word_o == '0 &&
               rf_ref_word_o == '0 && rf_div_word_o == '0));

  assert_ifref_guard_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(if_ref_word_o) |-> load_stb_o[0]);
  assert_ifdiv_guard_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(if_div_word_o) |-> load_stb_o[1]);
  assert_rfref_guard_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(rf_ref_word_o) |-> load_stb_o[2]);
  assert_rfdiv_guard_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(rf_div_word_o) |-> load_stb_o[3]);

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_stb_o));
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    (load_stb_o != '0) |=> (load_stb_o == '0));

  assert_gpo_load_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(gpo0_o) || !$stable(gpo1_o)) |-> load_stb_o[1]);
  assert_cp_load_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rf_cp_code_o) |-> load_stb_o[2]);
  assert_gain_load_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(if_cp_hi_o) |-> load_stb_o[0]);

endmodule

bind serial_cfg_port serial_cfg_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .if_ref_word_o (if_ref_word_o),
  .if_div_word_o (if_div_word_o),
  .rf_ref_word_o (rf_ref_word_o),
  .rf_div_word_o (rf_div_word_o),
  .rf_cp_code_o  (rf_cp_code_o),
  .if_cp_hi_o    (if_cp_hi_o),
  .gpo0_o        (gpo0_o),
  .gpo1_o        (gpo1_o),
  .load_stb_o    (load_stb_o)
);

// File: tb/serial_cfg_port_bench.sv
`timescale 1ns/1ps
module serial_cfg_port_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, le = 1'b0;
  logic [21:0] w_ifr, w_ifd, w_rfr, w_rfd;
  logic [3:0]  cp, stb;
  logic        gain, g0, g1;

  always #4 clk = ~clk;   // 125 MHz

  serial_cfg_port u_serial_cfg_port (
    .clk(clk), .rst(rst), .cfg_sclk_i(sclk), .cfg_sdat_i(sdat), .cfg_le_i(le),
    .if_ref_word_o(w_ifr), .if_div_word_o(w_ifd), .rf_ref_word_o(w_rfr),
    .rf_div_word_o(w_rfd), .rf_cp_code_o(cp), .if_cp_hi_o(gain),
    .gpo0_o(g0), .gpo1_o(g1), .load_stb_o(stb)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [23:0] exp_word [4];
  int stb_cnt = 0;
  logic [3:0] stb_last = '0;

  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    24'hA5A5A4, 24'h063FFD, 24'h3C0002, 24'hFFFFFF,
    24'h120001, 24'h100000, 24'h000002, 24'h0A5A5B
  };

  // Strobe monitor, sampled shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (stb != 4'd0) begin
      stb_cnt++;
      stb_last = stb;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] port_word(input int k);
    case (k)
      0: return w_ifr;
      1: return w_ifd;
      2: return w_rfr;
      default: return w_rfd;
    endcase
  endfunction

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) sdat = v[i];
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_le();
    @(negedge clk);
    stb_cnt = 0;
    le = 1'b1;
    repeat (6) @(negedge clk);
    le = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 4; k++)
      check({tag, " R3 word"}, 32'(port_word(k)), 32'(exp_word[k][23:2]));
    check({tag, " R6 gpo0"}, 32'(g0), 32'(exp_word[1][17]));
    check({tag, " R6 gpo1"}, 32'(g1), 32'(exp_word[1][18]));
    check({tag, " R7 cp code"}, 32'(cp), 32'(exp_word[2][21:18]));
    check({tag, " R8 if gain"}, 32'(gain), 32'(exp_word[0][20]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) exp_word[k] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state
    check_all("R1 reset");
    check("R1 strobe", 32'(stb), 32'd0);

    // Table walk: R2, R3, R5 to R8
    for (int v = 0; v < NV; v++) begin
      send_bits(32'(VEC[v]), 24);
      pulse_le();
      exp_word[VEC[v][1:0]] = VEC[v];
      check_all("R2 table");
      check("R5 strobe count", 32'(stb_cnt), 32'd1);
      check("R5 strobe bit", 32'(stb_last), 32'(4'd1 << VEC[v][1:0]));
    end

    // R10: latency of a load
    send_bits(32'h0ABCDE, 24);   // address 10
    @(negedge clk);
    stb_cnt = 0;
    le = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R10 before third edge", 32'(w_rfr), 32'(exp_word[2][23:2]));
    check("R10 strobe not yet", 32'(stb), 32'd0);
    @(posedge clk);
    #1;
    exp_word[2] = 24'h0ABCDE;
    check("R10 after third edge", 32'(w_rfr), 32'(exp_word[2][23:2]));
    check("R10 strobe now", 32'(stb), 32'd4);
    repeat (3) @(negedge clk);
    le = 1'b0;
    repeat (3) @(negedge clk);

    // R4: shifting while load enable is high has no effect until the next rising edge
    send_bits(32'h11111F, 24);   // address 11
    pulse_le();
    exp_word[3] = 24'h11111F;
    check_all("R4 setup");
    @(negedge clk);
    stb_cnt = 0;
    le = 1'b1;
    repeat (6) @(negedge clk);
    stb_cnt = 0;
    send_bits(32'h2222A3, 24);   // address 11, shifted with le high
    check("R4 held while high", 32'(w_rfd), 32'(exp_word[3][23:2]));
    check("R4 no strobe while high", 32'(stb_cnt), 32'd0);
    le = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 held after fall", 32'(w_rfd), 32'(exp_word[3][23:2]));
    pulse_le();
    exp_word[3] = 24'h2222A3;
    check("R4 loaded on next rise", 32'(w_rfd), 32'(exp_word[3][23:2]));
    check_all("R4 others");

    // R9: only the last 24 of 30 bits count
    send_bits({2'b00, 6'b111111, 24'h060005}, 30);
    pulse_le();
    exp_word[1] = 24'h060005;
    check_all("R9 overlong");
    check("R9 strobe bit", 32'(stb_last), 32'd2);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule